// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O Double-Data-Rate SRAM Model

This block is a synthesizable behavioural stand-in for a synchronous static RAM. It has separate write-data and read-data buses and one shared burst address. Each access moves four words. Two words cross per clock cycle, so one data lane carries the rising-edge word and a second lane carries the falling-edge word. Active-low read and write selects are sampled on the rising clock. Write words are captured starting in the command cycle. Read words are driven starting in the cycle after the command. An output-enable flag stands in for the high-impedance state of the read bus.

The model is meant as a target for controller verification. Reads and writes can alternate cycle by cycle, so the write burst of one command overlaps the read burst of the next on the two buses. The storage is a small array of words. Its burst count is a parameter and must be a power of two, at least 2.

Top module: `qb4_sram`

## Requirements
- R1: While reset is low, and on the first edge after it rises, rdDataOe is 0 and both read lanes are 0. No burst started before reset blocks the first command after it.
- R2: If rdSelN is low and the select is not blocked, the command is a read. This holds even when wrSelN is also low, in which case the write is dropped. If wrSelN is low, rdSelN is high and the write select is not blocked, the command is a write. If both selects are high, the cycle is idle.
- R3: A write to burst address A stores the rising and falling lanes of the command cycle as words 4A+0 and 4A+1. It stores the two lanes of the following cycle as words 4A+2 and 4A+3.
- R4: After a read of burst A, the cycle after the command shows words 4A+0 (rise lane) and 4A+1 (fall lane) with rdDataOe at 1. The cycle after that shows words 4A+2 and 4A+3 with rdDataOe at 1.
- R5: In the cycle after an accepted read, rdSelN has no effect. In the cycle after an accepted write, wrSelN has no effect.
- R6: A write may be accepted in the cycle right after a read, and a read in the cycle right after a write. Their bursts then overlap on the two buses.
- R7: In any cycle that is not one of the two read-data cycles of an accepted read, rdDataOe is 0 and both read lanes are 0. This applies after idle and write commands unless a read was accepted one cycle earlier.
- R8: A read accepted in the cycle right after a write to the same burst returns all four newly written words.
- R9: The highest burst address and burst address 0 hold separate data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands and write lanes sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Burst address for the command in this cycle |
| rdSelN | input | 1 | Active-low read select |
| wrSelN | input | 1 | Active-low write select |
| wrDataRise | input | WORD_W | Write word carried on the rising edge |
| wrDataFall | input | WORD_W | Write word carried on the falling edge |
| rdDataRise | output | WORD_W | Read word for the rising edge |
| rdDataFall | output | WORD_W | Read word for the falling edge |
| rdDataOe | output | 1 | Read bus driven (1) or high-impedance (0) |

## Verification
Commands are applied as isolated reads and writes, as alternating write-read-write chains, and as cycles with both selects low. These patterns separate read priority from write acceptance. They also separate the blocked-select rule from a plain second command. Each write burst uses a distinct value for every word, so a swapped lane, a swapped half or a lost second half shows up on the read side. Reads of a burst written just before, reads of the top and bottom burst addresses, and a reset in the middle of a read burst separate the forwarding, address-aliasing and reset-recovery cases from the steady-state path.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  // Burst position is two bits wide; four words per burst.
  localparam int BEAT_BITS = 2;

  typedef struct packed {
    logic wrLo;  // store beats 0 and 1 of a write
    logic wrHi;  // store beats 2 and 3 of a write
    logic rdLo;  // load beats 0 and 1 of a read
    logic rdHi;  // load beats 2 and 3 of a read
  } qb4_strobe_t;
endpackage

// File: rtl/qb4_ctrl.sv
module qb4_ctrl
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdSelN,
  input  logic              wrSelN,
  output qb4_strobe_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  logic              prevRead;
  logic              prevWrite;
  logic              readAcc;
  logic              writeAcc;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [ADDR_W-1:0] wrAddrQ;

  // A select is blocked in the cycle after its own command; read wins a tie.
  always_comb begin
    readAcc  = !rdSelN && !prevRead;
    writeAcc = !wrSelN && !prevWrite && !readAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRead  <= 1'b0;
      prevWrite <= 1'b0;
      rdAddrQ   <= '0;
      wrAddrQ   <= '0;
    end else begin
      prevRead  <= readAcc;
      prevWrite <= writeAcc;
      if (readAcc)  rdAddrQ <= addr;
      if (writeAcc) wrAddrQ <= addr;
    end
  end

  always_comb begin
    strb.wrLo = writeAcc;
    strb.wrHi = prevWrite;
    strb.rdLo = readAcc;
    strb.rdHi = prevRead;
    wrAddr    = writeAcc ? addr : wrAddrQ;
    rdAddr    = readAcc  ? addr : rdAddrQ;
  end
endmodule

// File: rtl/qb4_datapath.sv
module qb4_datapath
  import qb4_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  qb4_strobe_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] wrDataRise,
  input  logic [WORD_W-1:0] wrDataFall,
  output logic [WORD_W-1:0] rdDataRise,
  output logic [WORD_W-1:0] rdDataFall,
  output logic              rdDataOe
);
  localparam int WORDS  = (1 << ADDR_W) << BEAT_BITS;
  localparam int WIDX_W = ADDR_W + BEAT_BITS;

  logic [WORD_W-1:0] mem [WORDS];

  // Each half of a burst is a pair of words: even word on rise, odd on fall.
  logic [WIDX_W-1:0] wrIdxEven;
  logic [WIDX_W-1:0] wrIdxOdd;
  logic [WIDX_W-1:0] rdIdxEven;
  logic [WIDX_W-1:0] rdIdxOdd;

  always_comb begin
    wrIdxEven = {wrAddr, strb.wrHi, 1'b0};
    wrIdxOdd  = {wrAddr, strb.wrHi, 1'b1};
    rdIdxEven = {rdAddr, strb.rdHi, 1'b0};
    rdIdxOdd  = {rdAddr, strb.rdHi, 1'b1};
  end

  // Array: wrLo and wrHi never coincide, so one index pair covers both halves.
  always_ff @(posedge clk) begin
    if (strb.wrLo || strb.wrHi) begin
      mem[wrIdxEven] <= wrDataRise;
      mem[wrIdxOdd]  <= wrDataFall;
    end
  end

  // Output lanes: registered, zero while the bus is released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataRise <= '0;
      rdDataFall <= '0;
      rdDataOe   <= 1'b0;
    end else if (strb.rdLo || strb.rdHi) begin
      rdDataRise <= mem[rdIdxEven];
      rdDataFall <= mem[rdIdxOdd];
      rdDataOe   <= 1'b1;
    end else begin
      rdDataRise <= '0;
      rdDataFall <= '0;
      rdDataOe   <= 1'b0;
    end
  end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
  import qb4_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [WORD_W-1:0] wrDataRise,
  input  logic [WORD_W-1:0] wrDataFall,
  output logic [WORD_W-1:0] rdDataRise,
  output logic [WORD_W-1:0] rdDataFall,
  output logic              rdDataOe
);
  qb4_strobe_t       strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  qb4_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .strb   (strb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr)
  );

  qb4_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .wrDataRise (wrDataRise),
    .wrDataFall (wrDataFall),
    .rdDataRise (rdDataRise),
    .rdDataFall (rdDataFall),
    .rdDataOe   (rdDataOe)
  );
endmodule

// File: rtl/qb4_checker.sv
module qb4_checker
  import qb4_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdSelN,
  input qb4_strobe_t       strb,
  input logic [WORD_W-1:0] rdDataRise,
  input logic [WORD_W-1:0] rdDataFall,
  input logic              rdDataOe
);
  // R2: an unblocked read select is taken as a read and suppresses any write
  p_read_priority_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSelN && !strb.rdHi) |-> (strb.rdLo && !strb.wrLo));

  // R3: a write always stores its second half on the next cycle
  p_write_second_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> strb.wrHi);

  // R4: the bus is driven in the first read-data cycle
  p_read_first_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLo |=> rdDataOe);

  // R4: and in the second one
  p_read_second_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLo |=> ##1 rdDataOe);

  // R5: no read is accepted in the cycle after a read
  p_read_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLo |=> !strb.rdLo);

  // R5: no write is accepted in the cycle after a write
  p_write_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> !strb.wrLo);

  // R7: outside read-data cycles the bus is released and quiet
  p_bus_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdLo && !strb.rdHi) |=>
      (!rdDataOe && rdDataRise == '0 && rdDataFall == '0));
endmodule

bind qb4_sram qb4_checker #(.WORD_W(WORD_W)) u_qb4_checker (
  .clk        (clk),
  .rstN       (rstN),
  .rdSelN     (rdSelN),
  .strb       (strb),
  .rdDataRise (rdDataRise),
  .rdDataFall (rdDataFall),
  .rdDataOe   (rdDataOe)
);

// File: tb/qb4_sram_bench.sv
module qb4_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 36;
  localparam int DEPTH      = 64;
  localparam int ADDR_W     = $clog2(DEPTH);

  typedef struct packed {
    logic [15:0]       tag;
    logic              rdN;
    logic              wrN;
    logic [ADDR_W-1:0] adr;
    logic [WORD_W-1:0] dR;
    logic [WORD_W-1:0] dF;
    logic              eOe;
    logic [WORD_W-1:0] eR;
    logic [WORD_W-1:0] eF;
  } vec_t;

  localparam int NVEC = 22;
  // Each row: inputs before an edge, expected outputs just after that edge.
  localparam vec_t VECS [NVEC] = '{
    '{"R7", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b0, 36'h0,   36'h0},
    '{"R3", 1'b1, 1'b0, 6'd5,  36'h501, 36'h502, 1'b0, 36'h0,   36'h0},
    '{"R8", 1'b0, 1'b0, 6'd5,  36'h503, 36'h504, 1'b1, 36'h501, 36'h502},
    '{"R6", 1'b0, 1'b0, 6'd9,  36'h901, 36'h902, 1'b1, 36'h503, 36'h504},
    '{"R7", 1'b1, 1'b0, 6'd5,  36'h903, 36'h904, 1'b0, 36'h0,   36'h0},
    '{"R2", 1'b0, 1'b0, 6'd9,  36'hBAD, 36'hBAD, 1'b1, 36'h901, 36'h902},
    '{"R7", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b1, 36'h903, 36'h904},
    '{"R7", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b0, 36'h0,   36'h0},
    '{"R5", 1'b0, 1'b1, 6'd5,  36'h0,   36'h0,   1'b1, 36'h501, 36'h502},
    '{"R5", 1'b0, 1'b1, 6'd5,  36'h0,   36'h0,   1'b1, 36'h503, 36'h504},
    '{"R5", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b0, 36'h0,   36'h0},
    '{"R2", 1'b0, 1'b1, 6'd9,  36'h0,   36'h0,   1'b1, 36'h901, 36'h902},
    '{"R4", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b1, 36'h903, 36'h904},
    '{"R9", 1'b1, 1'b0, 6'd63, 36'hF01, 36'hF02, 1'b0, 36'h0,   36'h0},
    '{"R3", 1'b1, 1'b1, 6'd0,  36'hF03, 36'hF04, 1'b0, 36'h0,   36'h0},
    '{"R9", 1'b1, 1'b0, 6'd0,  36'h001, 36'h002, 1'b0, 36'h0,   36'h0},
    '{"R3", 1'b1, 1'b1, 6'd0,  36'h003, 36'h004, 1'b0, 36'h0,   36'h0},
    '{"R9", 1'b0, 1'b1, 6'd63, 36'h0,   36'h0,   1'b1, 36'hF01, 36'hF02},
    '{"R9", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b1, 36'hF03, 36'hF04},
    '{"R9", 1'b0, 1'b1, 6'd0,  36'h0,   36'h0,   1'b1, 36'h001, 36'h002},
    '{"R4", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b1, 36'h003, 36'h004},
    '{"R7", 1'b1, 1'b1, 6'd0,  36'h0,   36'h0,   1'b0, 36'h0,   36'h0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdSelN = 1'b1;
  logic              wrSelN = 1'b1;
  logic [WORD_W-1:0] wrDataRise = '0;
  logic [WORD_W-1:0] wrDataFall = '0;
  logic [WORD_W-1:0] rdDataRise;
  logic [WORD_W-1:0] rdDataFall;
  logic              rdDataOe;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qb4_sram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_qb4_sram (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .rdSelN     (rdSelN),
    .wrSelN     (wrSelN),
    .wrDataRise (wrDataRise),
    .wrDataFall (wrDataFall),
    .rdDataRise (rdDataRise),
    .rdDataFall (rdDataFall),
    .rdDataOe   (rdDataOe)
  );

  task automatic checkOut(input logic [15:0] tag, input logic eOe,
                          input logic [WORD_W-1:0] eR, input logic [WORD_W-1:0] eF);
    testCount++;
    if (rdDataOe !== eOe || rdDataRise !== eR || rdDataFall !== eF) begin
      failCount++;
      $display("FAIL %s: oe=%0b rise=%h fall=%h expected oe=%0b rise=%h fall=%h",
               tag, rdDataOe, rdDataRise, rdDataFall, eOe, eR, eF);
    end
  endtask

  // Drive one cycle of inputs, then sample just after the capturing edge.
  task automatic step(input logic rdN, input logic wrN, input logic [ADDR_W-1:0] a,
                      input logic [WORD_W-1:0] dR, input logic [WORD_W-1:0] dF);
    @(negedge clk);
    rdSelN = rdN;
    wrSelN = wrN;
    addr = a;
    wrDataRise = dR;
    wrDataFall = dF;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failCount++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1", 1'b0, '0, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkOut("R1", 1'b0, '0, '0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].rdN, VECS[i].wrN, VECS[i].adr, VECS[i].dR, VECS[i].dF);
      checkOut(VECS[i].tag, VECS[i].eOe, VECS[i].eR, VECS[i].eF);
    end

    // R1: reset in the middle of a read burst, then an immediate new read
    step(1'b0, 1'b1, 6'd5, '0, '0);
    checkOut("R4", 1'b1, 36'h501, 36'h502);
    @(negedge clk);
    rdSelN = 1'b1;
    rstN = 1'b0;
    #1;
    checkOut("R1", 1'b0, '0, '0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b1, 6'd9, '0, '0);
    checkOut("R1", 1'b1, 36'h901, 36'h902);
    step(1'b1, 1'b1, 6'd0, '0, '0);
    checkOut("R4", 1'b1, 36'h903, 36'h904);
    step(1'b1, 1'b1, 6'd0, '0, '0);
    checkOut("R7", 1'b0, '0, '0);

    // R6: read then write back to back, then read the written burst
    step(1'b0, 1'b1, 6'd63, '0, '0);
    checkOut("R6", 1'b1, 36'hF01, 36'hF02);
    step(1'b1, 1'b0, 6'd12, 36'hC01, 36'hC02);
    checkOut("R6", 1'b1, 36'hF03, 36'hF04);
    step(1'b1, 1'b1, 6'd0, 36'hC03, 36'hC04);
    checkOut("R7", 1'b0, '0, '0);
    step(1'b0, 1'b1, 6'd12, '0, '0);
    checkOut("R3", 1'b1, 36'hC01, 36'hC02);
    step(1'b1, 1'b1, 6'd0, '0, '0);
    checkOut("R3", 1'b1, 36'hC03, 36'hC04);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule